// File: doc/BRIEF.md
# Three-Wire Codec Control Bus Master

This block turns single register writes from a host into bit-serial transfers on a three-wire codec control bus made of a clock line, a data line and a mode line. The host offers a request on a valid/ready handshake: a register kind (direct bank 0, direct bank 1, status, or extended) together with a payload byte and, for extended writes, a register index. The block first shifts out an address byte with the mode line low, then raises the mode line and shifts out one data byte, or two for an extended write.

Every bus interval is stretched to a minimum width. Each minimum is given in nanoseconds and turned into a cycle count from the system clock frequency parameter. Extended writes are built inside the block. The first byte is an escape code that carries a sub-address, and the second byte carries a five-bit value. The index-to-sub-address map skips code 3.

Top module: `codec_ctl_master`

## Requirements
- R1: After reset, and after any reset applied in the middle of a transfer, req_ready is 1, bus_clk is 1, bus_mode is 1 and bus_dat_oe is 0.
- R2: Each transfer starts with an address byte. The 6-bit device address (default 5) sits in bits 7:2 and the type sits in bits 1:0. The type is 0 for kind 0, 1 for kind 1, 2 for kind 2 and 0 for kind 3 (extended). The byte is shifted LSB first while bus_mode is 0.
- R3: For kinds 0, 1 and 2, exactly one data byte follows, equal to req_byte, shifted LSB first while bus_mode is 1.
- R4: For kind 3, two data bytes follow with bus_mode 1. The first is {2'b11, 3'b000, sub[2:0]} and the second is {3'b111, req_byte[4:0]}.
- R5: The extended index req_ext_sel maps to a sub-address: 0, 1 and 2 map to themselves, 3 maps to 4, 4 maps to 5, and 5, 6 and 7 all map to 6. Sub-address 3 is never sent.
- R6: bus_clk idles high. bus_dat_o changes only on the cycle bus_clk falls and is stable while bus_clk is high. bus_mode changes only while bus_clk is high.
- R7: Every low phase of bus_clk lasts at least ceil(max(250, 190) ns × f) cycles. Every high phase between pulses lasts at least ceil(max(250, 30) ns × f) cycles.
- R8: At least ceil(190 ns × f) cycles pass from a bus_mode change to the next falling edge of bus_clk. At least the same number pass from the last rising edge of the address byte to the rise of bus_mode.
- R9: req_ready drops in the cycle after a request is accepted. It returns only after at least ceil(190 ns × f) cycles have passed since bus_dat_oe fell.
- R10: A request held valid while the block is busy is accepted once req_ready returns, and it is sent after the current transfer. Nothing is dropped.
- R11: bus_dat_oe is 1 from acceptance until the end of the last mode-hold interval, and 0 while idle. bus_clk pulses low only while bus_dat_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and will take a request |
| req_kind | input | 2 | 0 bank 0, 1 bank 1, 2 status, 3 extended |
| req_ext_sel | input | 3 | Extended register index (kind 3) |
| req_byte | input | 8 | Data byte, or the value in bits 4:0 for kind 3 |
| bus_clk | output | 1 | Bus clock line |
| bus_mode | output | 1 | Mode line: 0 for address, 1 for data |
| bus_dat_o | output | 1 | Data line value |
| bus_dat_oe | output | 1 | Data line output enable |

## Verification
A wrong bit or byte counter shows up within one byte time, which is about a thousand cycles at the default clock. It appears as a byte of the wrong value, a byte of the wrong length, or a byte shifted under the wrong mode level. A timing counter that is loaded wrongly shows up on the very next phase as a pulse, setup or halt that is too short. A state machine that never returns to idle shows up as req_ready staying low, which holds off every later request. The bench decodes the bus from the ports alone and measures each interval in cycles, so each of these faults fails a check within the transfer where it occurs.

// File: rtl/codec_ctl_master.sv
module codec_ctl_master #(
  parameter int CLK_MHZ   = 250,
  parameter int DEV_ADDR  = 5,
  parameter int T_DS_NS   = 190,
  parameter int T_DH_NS   = 30,
  parameter int T_MS_NS   = 190,
  parameter int T_MH_NS   = 190,
  parameter int T_HI_NS   = 250,
  parameter int T_LO_NS   = 250,
  parameter int T_HALT_NS = 190
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_kind,
  input  logic [2:0] req_ext_sel,
  input  logic [7:0] req_byte,
  output logic       bus_clk,
  output logic       bus_mode,
  output logic       bus_dat_o,
  output logic       bus_dat_oe
);

  function automatic int ns2cyc(int ns);
    int c;
    c = (ns * CLK_MHZ + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LO_C   = imax(ns2cyc(T_LO_NS), ns2cyc(T_DS_NS));
  localparam int HI_C   = imax(ns2cyc(T_HI_NS), ns2cyc(T_DH_NS));
  localparam int MS_C   = ns2cyc(T_MS_NS);
  localparam int MH_C   = ns2cyc(T_MH_NS);
  localparam int HALT_C = ns2cyc(T_HALT_NS);
  localparam int MAX_C  = imax(imax(LO_C, HI_C), imax(imax(MS_C, MH_C), HALT_C));
  localparam int CW     = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_MSET, S_LOW, S_HIGH, S_MHOLD, S_HALT} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [7:0]    sh, nxt_a, nxt_b;
  logic [2:0]    bit_i;
  logic [1:0]    byte_i;
  logic          two;

  wire       is_ext = (req_kind == 2'd3);
  wire [1:0] typ    = is_ext ? 2'd0 : req_kind;
  wire [7:0] addr_b = {6'(DEV_ADDR), typ};
  wire [2:0] sub    = (req_ext_sel < 3'd3) ? req_ext_sel :
                      (req_ext_sel >= 3'd5) ? 3'd6 : req_ext_sel + 3'd1;
  wire [7:0] ext_a  = {2'b11, 3'b000, sub};
  wire [7:0] ext_b  = {3'b111, req_byte[4:0]};
  wire       tick   = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      sh         <= '0;
      nxt_a      <= '0;
      nxt_b      <= '0;
      bit_i      <= '0;
      byte_i     <= '0;
      two        <= 1'b0;
      req_ready  <= 1'b1;
      bus_clk    <= 1'b1;
      bus_mode   <= 1'b1;
      bus_dat_o  <= 1'b0;
      bus_dat_oe <= 1'b0;
    end else begin
      if (st != S_IDLE && !tick) cnt <= cnt - 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          req_ready  <= 1'b0;
          bus_dat_oe <= 1'b1;
          bus_mode   <= 1'b0;
          sh         <= addr_b;
          nxt_a      <= is_ext ? ext_a : req_byte;
          nxt_b      <= ext_b;
          two        <= is_ext;
          byte_i     <= 2'd0;
          bit_i      <= 3'd0;
          cnt        <= CW'(MS_C - 1);
          st         <= S_MSET;
        end
        S_MSET: if (tick) begin
          bus_clk   <= 1'b0;
          bus_dat_o <= sh[0];
          cnt       <= CW'(LO_C - 1);
          st        <= S_LOW;
        end
        S_LOW: if (tick) begin
          bus_clk <= 1'b1;
          cnt     <= CW'(HI_C - 1);
          st      <= S_HIGH;
        end
        S_HIGH: if (tick) begin
          if (bit_i != 3'd7) begin
            bit_i     <= bit_i + 3'd1;
            sh        <= sh >> 1;
            bus_clk   <= 1'b0;
            bus_dat_o <= sh[1];
            cnt       <= CW'(LO_C - 1);
            st        <= S_LOW;
          end else begin
            bit_i <= 3'd0;
            if (byte_i == 2'd1 && two) begin
              byte_i    <= 2'd2;
              sh        <= nxt_b;
              bus_clk   <= 1'b0;
              bus_dat_o <= nxt_b[0];
              cnt       <= CW'(LO_C - 1);
              st        <= S_LOW;
            end else begin
              cnt <= CW'(MH_C - 1);
              st  <= S_MHOLD;
            end
          end
        end
        S_MHOLD: if (tick) begin
          if (byte_i == 2'd0) begin
            bus_mode <= 1'b1;
            byte_i   <= 2'd1;
            sh       <= nxt_a;
            cnt      <= CW'(MS_C - 1);
            st       <= S_MSET;
          end else begin
            bus_dat_oe <= 1'b0;
            cnt        <= CW'(HALT_C - 1);
            st         <= S_HALT;
          end
        end
        S_HALT: if (tick) begin
          req_ready <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/codec_ctl_master_chk.sv
module codec_ctl_master_chk #(
  parameter int CLK_MHZ = 250
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic bus_clk,
  input logic bus_mode,
  input logic bus_dat_o,
  input logic bus_dat_oe
);

  localparam int LO_MIN = (250 * CLK_MHZ + 999) / 1000;
  localparam int HI_MIN = (250 * CLK_MHZ + 999) / 1000;

  logic [31:0] low_cnt, hi_cnt;
  logic        clk_q, armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt <= '0;
      hi_cnt  <= '0;
      clk_q   <= 1'b1;
      armed   <= 1'b0;
    end else begin
      low_cnt <= bus_clk ? '0 : low_cnt + 1;
      hi_cnt  <= bus_clk ? hi_cnt + 1 : '0;
      clk_q   <= bus_clk;
      armed   <= !bus_clk ? 1'b0 : (!clk_q ? 1'b1 : armed);
    end
  end

  AST_DAT_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) bus_clk |-> $stable(bus_dat_o)); // R6
  AST_MODE_STABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !bus_clk |-> $stable(bus_mode)); // R6
  AST_CLK_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) (bus_clk && !clk_q) |-> low_cnt >= LO_MIN); // R7
  AST_CLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) (!bus_clk && clk_q && armed) |-> hi_cnt >= HI_MIN); // R7
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> (!req_ready && !bus_mode)); // R9
  AST_READY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (!bus_dat_oe && bus_clk && bus_mode)); // R11
  AST_LOW_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !bus_clk |-> bus_dat_oe); // R11
  AST_MODE_LOW_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) !bus_mode |-> bus_dat_oe); // R2

endmodule

bind codec_ctl_master codec_ctl_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .bus_clk(bus_clk), .bus_mode(bus_mode), .bus_dat_o(bus_dat_o), .bus_dat_oe(bus_dat_oe)
);

// File: tb/test_codec_ctl_master.sv
`timescale 1ns/1ps
module test_codec_ctl_master;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [2:0] req_ext_sel = '0;
  logic [7:0] req_byte = '0;
  logic req_ready, bus_clk, bus_mode, bus_dat_o, bus_dat_oe;

  always #2 clk = ~clk;

  codec_ctl_master i_codec_ctl_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_ext_sel(req_ext_sel), .req_byte(req_byte),
    .bus_clk(bus_clk), .bus_mode(bus_mode), .bus_dat_o(bus_dat_o), .bus_dat_oe(bus_dat_oe)
  );

  function automatic int cyc(int ns);
    return (ns * 250 + 999) / 1000;
  endfunction

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor, sampled on the falling system clock edge
  logic [7:0] cap_b [0:63];
  int         cap_m [0:63];
  int  cap_total = 0, bitn = 0, m0 = 0;
  bit  mmix = 0;
  logic [7:0] shv = '0;
  int  lowrun = 0, hirun = 0, since_mode = 0, since_rise = 0, since_oe_fall = 0;
  int  min_low = 1000000, min_high = 1000000, min_ms = 1000000, min_mh = 1000000, min_gap = 1000000;
  int  viol_edge = 0, viol_oe = 0;
  bit  prev_sclk = 1, prev_mode = 1, prev_oe = 0, prev_ready = 1, prev_dat = 0;
  bit  rise_ok = 0, hi_ok = 0, ms_pend = 0, gap_pend = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      bitn = 0; rise_ok = 0; hi_ok = 0; ms_pend = 0; gap_pend = 0; lowrun = 0;
    end else begin
      if (bus_clk && !prev_sclk) begin
        if (lowrun < min_low) min_low = lowrun;
        if (bus_dat_oe) begin
          shv[bitn] = bus_dat_o;
          if (bitn == 0) begin m0 = bus_mode; mmix = 0; end
          else if (bus_mode != m0) mmix = 1;
          bitn++;
          if (bitn == 8) begin
            cap_b[cap_total % 64] = shv;
            cap_m[cap_total % 64] = mmix ? 2 : m0;
            cap_total++;
            bitn = 0;
          end
        end
        rise_ok = 1; since_rise = 0; hirun = 0; hi_ok = 1;
      end
      if (!bus_clk && prev_sclk) begin
        if (hi_ok && hirun < min_high) min_high = hirun;
        hi_ok = 0;
        if (ms_pend) begin
          if (since_mode < min_ms) min_ms = since_mode;
          ms_pend = 0;
        end
        lowrun = 0;
      end
      if (bus_mode != prev_mode) begin
        if (rise_ok && since_rise < min_mh) min_mh = since_rise;
        since_mode = 0; ms_pend = 1;
        if (!bus_clk) viol_edge++;
      end
      if (bus_clk && prev_sclk && bus_dat_oe && bus_dat_o != prev_dat) viol_edge++;
      if (!bus_dat_oe && !bus_clk) viol_oe++;
      if (!bus_dat_oe && prev_oe) begin gap_pend = 1; since_oe_fall = 0; rise_ok = 0; end
      if (req_ready && !prev_ready && gap_pend) begin
        if (since_oe_fall < min_gap) min_gap = since_oe_fall;
        gap_pend = 0;
      end
      if (!bus_clk) lowrun++;
      if (bus_clk) hirun++;
      since_mode++; since_rise++; since_oe_fall++;
    end
    prev_sclk = bus_clk; prev_mode = bus_mode; prev_oe = bus_dat_oe;
    prev_ready = req_ready; prev_dat = bus_dat_o;
  end

  task automatic send(input logic [1:0] k, input logic [2:0] s, input logic [7:0] b);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_ext_sel = s; req_byte = b;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!req_ready);
  endtask

  // {kind, sel, byte, ndata, addr, d1, d2}
  localparam logic [38:0] VEC [0:8] = '{
    {2'd0, 3'd0, 8'h3F, 2'd1, 8'h14, 8'h3F, 8'h00},
    {2'd1, 3'd0, 8'hA5, 2'd1, 8'h15, 8'hA5, 8'h00},
    {2'd2, 3'd0, 8'h81, 2'd1, 8'h16, 8'h81, 8'h00},
    {2'd0, 3'd0, 8'h84, 2'd1, 8'h14, 8'h84, 8'h00},
    {2'd3, 3'd0, 8'h1F, 2'd2, 8'h14, 8'hC0, 8'hFF},
    {2'd3, 3'd3, 8'h0A, 2'd2, 8'h14, 8'hC4, 8'hEA},
    {2'd3, 3'd5, 8'hF3, 2'd2, 8'h14, 8'hC6, 8'hF3},
    {2'd3, 3'd2, 8'h00, 2'd2, 8'h14, 8'hC2, 8'hE0},
    {2'd3, 3'd7, 8'h05, 2'd2, 8'h14, 8'hC6, 8'hE5}
  };

  initial begin
    repeat (5) @(negedge clk);
    chk(req_ready == 1 && bus_clk == 1 && bus_mode == 1 && bus_dat_oe == 0, "R1 reset",
        {req_ready, bus_clk, bus_mode, bus_dat_oe}, 4'b1110);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(bus_dat_oe == 0, "R11 idle oe", bus_dat_oe, 0);

    for (int i = 0; i < 9; i++) begin
      logic [38:0] v;
      int base, nd;
      v = VEC[i];
      nd = v[25:24];
      base = cap_total;
      send(v[38:37], v[36:34], v[33:26]);
      chk(req_ready == 0, "R9 ready low after accept", req_ready, 0);
      wait_idle();
      chk(cap_total - base == nd + 1, "R3/R4 byte count", cap_total - base, nd + 1);
      chk(cap_b[base % 64] == v[23:16] && cap_m[base % 64] == 0, "R2 address byte",
          cap_b[base % 64], v[23:16]);
      chk(cap_b[(base + 1) % 64] == v[15:8] && cap_m[(base + 1) % 64] == 1,
          (v[38:37] == 2'd3) ? "R4 R5 escape byte" : "R3 data byte", cap_b[(base + 1) % 64], v[15:8]);
      if (nd == 2)
        chk(cap_b[(base + 2) % 64] == v[7:0] && cap_m[(base + 2) % 64] == 1, "R4 value byte",
            cap_b[(base + 2) % 64], v[7:0]);
    end

    begin
      int base;
      base = cap_total;
      send(2'd1, 3'd0, 8'h5A);
      send(2'd3, 3'd4, 8'h11);
      wait_idle();
      chk(cap_total - base == 5, "R10 held request count", cap_total - base, 5);
      chk(cap_b[(base + 1) % 64] == 8'h5A, "R10 first transfer", cap_b[(base + 1) % 64], 8'h5A);
      chk(cap_b[(base + 2) % 64] == 8'h14 && cap_b[(base + 3) % 64] == 8'hC5 &&
          cap_b[(base + 4) % 64] == 8'hF1, "R10 R5 held second transfer",
          cap_b[(base + 3) % 64], 8'hC5);
    end

    chk(min_low >= cyc(250), "R7 clock low", min_low, cyc(250));
    chk(min_high >= cyc(250), "R7 clock high", min_high, cyc(250));
    chk(min_ms >= cyc(190), "R8 mode setup", min_ms, cyc(190));
    chk(min_mh >= cyc(190), "R8 mode hold", min_mh, cyc(190));
    chk(min_gap >= cyc(190), "R9 halt before ready", min_gap, cyc(190));
    chk(viol_edge == 0, "R6 edge discipline", viol_edge, 0);
    chk(viol_oe == 0, "R11 clock only while driving", viol_oe, 0);

    send(2'd3, 3'd1, 8'h07);
    repeat (400) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(req_ready == 1 && bus_clk == 1 && bus_mode == 1 && bus_dat_oe == 0, "R1 mid-transfer reset",
        {req_ready, bus_clk, bus_mode, bus_dat_oe}, 4'b1110);
    rst_n = 1;
    repeat (10) @(negedge clk);
    chk(req_ready == 1 && bus_dat_oe == 0, "R11 idle after reset", bus_dat_oe, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule